// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block holds the protection fields of a serial-flash status register. It answers three questions for the command logic around it. May a program or erase go to a given sector of a 64-sector array? May a whole-chip erase start? May a status-register write change the protection fields? A write-enable latch gates every modifying request. Software arms the latch with its own strobe, and the latch drops after each request, whether that request is granted or refused.

The protected region is a contiguous run of sectors anchored at one end of the array. A three-bit block-protect code sets its size in powers of two, and a direction bit chooses the end it grows from. A status-register write-disable bit together with a low level on the hardware write-protect pin makes the block-protect code and the write-disable bit read-only.

Each request is answered one clock later with a one-cycle grant or a one-cycle reject pulse.

Top module: `flash_sector_guard`

## Requirements
- R1: After reset, every protection field (dir, bp, srwd), the write-enable latch, grant and reject are all 0, so the array is fully unprotected.
- R2: A pulse on wen_set sets wel. Any request (sr_wr, ce_req or op_req) clears wel in the next cycle. When wen_set and a request arrive in the same cycle, the request is judged on the old wel and wel ends up 0.
- R3: A request made while wel is 0 is rejected, and a refused status write leaves every field unchanged.
- R4: A status write made while wel is 1 and the fields are not frozen is granted and loads srwd from sr_wdata[4], dir from sr_wdata[3] and bp from sr_wdata[2:0].
- R5: The fields are frozen when srwd is 1 and wp_n is 0. A status write made with wel set is then still granted and still loads dir, but bp and srwd keep their values. With wp_n at 1, srwd does not freeze anything.
- R6: The protected count N is 0 for bp code 0. For codes 1 to 6 it is 2^(code-1), which gives 1, 2, 4, 8, 16 or 32 sectors.
- R7: With dir = 0 the range is anchored at the top of the array: a sector op on index s is rejected when s >= 64 - N and granted otherwise (wel set).
- R8: With dir = 1 the range is anchored at the bottom: a sector op on s is rejected when s < N and granted otherwise (wel set).
- R9: bp code 7 protects all 64 sectors, whatever the value of dir.
- R10: A whole-chip erase is granted only when wel is 1 and bp is 0. The value of dir has no effect on it.
- R11: grant and reject are registered and appear in the cycle after a request. Exactly one of them is high after each request, and both stay low after a cycle with no request.
- R12: When requests arrive together, only one is judged: a status write wins over a chip erase, and a chip erase wins over a sector op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wen_set | input | 1 | Arms the write-enable latch |
| sr_wr | input | 1 | Status-register write strobe |
| sr_wdata | input | 5 | Write data: [4] srwd, [3] dir, [2:0] bp |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| ce_req | input | 1 | Whole-chip erase request |
| op_req | input | 1 | Sector program/erase request |
| op_sector | input | 6 | Sector index for op_req |
| grant | output | 1 | Previous request accepted |
| reject | output | 1 | Previous request refused |
| wel | output | 1 | Write-enable latch |
| dir | output | 1 | Protection anchor: 0 top, 1 bottom |
| srwd | output | 1 | Status-register write-disable bit |
| bp | output | 3 | Block-protect code |

## Verification
The assertions assume that strobes are sampled clean at the rising edge and that wp_n, sr_wdata and op_sector are stable while a strobe is high. They also assume that simultaneous requests resolve by the stated priority, so the checks on chip erase and sector ops are qualified by the absence of a higher-priority request. The bench changes every input on the falling edge and raises each strobe for exactly one cycle. It drives overlapping requests only in the directed priority and latch-race cases.

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
  parameter int SECT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_set,
  input  logic              sr_wr,
  input  logic [4:0]        sr_wdata,
  input  logic              wp_n,
  input  logic              ce_req,
  input  logic              op_req,
  input  logic [SECT_W-1:0] op_sector,
  output logic              grant,
  output logic              reject,
  output logic              wel,
  output logic              dir,
  output logic              srwd,
  output logic [2:0]        bp
);
  localparam int NSECT = 1 << SECT_W;
  localparam int CW    = SECT_W + 1;

  logic [CW-1:0] prot_n;
  logic          in_prot, frozen, any_req, ok;

  always_comb begin
    case (bp)
      3'd0:    prot_n = '0;
      3'd7:    prot_n = CW'(NSECT);
      default: prot_n = CW'(1) << (bp - 3'd1);
    endcase
  end

  assign in_prot = dir ? ({1'b0, op_sector} <  prot_n)
                       : ({1'b0, op_sector} >= CW'(NSECT) - prot_n);
  assign frozen  = srwd & ~wp_n;
  assign any_req = sr_wr | ce_req | op_req;
  assign ok      = sr_wr  ? wel :
                   ce_req ? (wel & (bp == 3'd0)) :
                            (wel & ~in_prot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= 1'b0;
      reject <= 1'b0;
      wel    <= 1'b0;
      dir    <= 1'b0;
      srwd   <= 1'b0;
      bp     <= 3'd0;
    end else begin
      grant  <= any_req & ok;
      reject <= any_req & ~ok;
      if (any_req)      wel <= 1'b0;
      else if (wen_set) wel <= 1'b1;
      if (sr_wr && wel) begin
        dir <= sr_wdata[3];
        if (!frozen) begin
          srwd <= sr_wdata[4];
          bp   <= sr_wdata[2:0];
        end
      end
    end
  end
endmodule

// File: rtl/flash_sector_guard_chk.sv
module flash_sector_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sr_wr,
  input logic       wp_n,
  input logic       ce_req,
  input logic       op_req,
  input logic       grant,
  input logic       reject,
  input logic       wel,
  input logic       dir,
  input logic       srwd,
  input logic [2:0] bp
);
  logic any_req;
  assign any_req = sr_wr | ce_req | op_req;

  p_mutex_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && reject));
  p_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> (grant || reject));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> (!grant && !reject));
  p_wel_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !wel);
  p_no_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !wel) |=> reject);
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && srwd && !wp_n) |=> ($stable(bp) && $stable(srwd)));
  p_fields_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_wr && wel) |=> $stable({dir, srwd, bp}));
  p_chip_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_req && !sr_wr && bp != 3'd0) |=> reject);
  p_all_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && !sr_wr && !ce_req && bp == 3'd7) |=> reject);
endmodule

bind flash_sector_guard flash_sector_guard_chk u_chk (.*);

// File: tb/flash_sector_guard_test.sv
module flash_sector_guard_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wen_set = 0, sr_wr = 0, wp_n = 1, ce_req = 0, op_req = 0;
  logic [4:0] sr_wdata = '0;
  logic [5:0] op_sector = '0;
  logic grant, reject, wel, dir, srwd;
  logic [2:0] bp;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_sector_guard uut (.*);

  // {dir, bp, sector, expected grant}: R6 sizes, R7 top, R8 bottom, R9 all
  localparam logic [10:0] VEC [17] = '{
    {1'b0, 3'd1, 6'd63, 1'b0}, {1'b0, 3'd1, 6'd62, 1'b1},
    {1'b0, 3'd2, 6'd62, 1'b0}, {1'b0, 3'd2, 6'd61, 1'b1},
    {1'b0, 3'd3, 6'd60, 1'b0}, {1'b0, 3'd6, 6'd32, 1'b0},
    {1'b0, 3'd6, 6'd31, 1'b1}, {1'b0, 3'd7, 6'd0,  1'b0},
    {1'b0, 3'd0, 6'd63, 1'b1},
    {1'b1, 3'd1, 6'd0,  1'b0}, {1'b1, 3'd1, 6'd1,  1'b1},
    {1'b1, 3'd4, 6'd7,  1'b0}, {1'b1, 3'd4, 6'd8,  1'b1},
    {1'b1, 3'd5, 6'd15, 1'b0}, {1'b1, 3'd5, 6'd16, 1'b1},
    {1'b1, 3'd7, 6'd63, 1'b0}, {1'b1, 3'd0, 6'd0,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, s, c, o, input logic [4:0] d, input logic [5:0] sec);
    @(negedge clk);
    wen_set = w; sr_wr = s; ce_req = c; op_req = o; sr_wdata = d; op_sector = sec;
    @(negedge clk);
    wen_set = 0; sr_wr = 0; ce_req = 0; op_req = 0;
  endtask

  task automatic cfg(input logic dr, input logic [2:0] code, input logic wd);
    step(1, 0, 0, 0, '0, '0);
    step(0, 1, 0, 0, {wd, dr, code}, '0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset fields", {wel, dir, srwd, bp, grant, reject}, 0);
    rst_n = 1;

    step(0, 1, 0, 0, 5'h1F, '0);
    chk("R3 status write without wel rejected", {grant, reject}, 2'b01);
    chk("R3 fields unchanged", {srwd, dir, bp}, 0);
    step(0, 0, 0, 1, '0, 6'd5);
    chk("R3 sector op without wel", {grant, reject}, 2'b01);

    step(1, 0, 0, 0, '0, '0);
    chk("R2 wel set", wel, 1);
    step(0, 0, 0, 1, '0, 6'd5);
    chk("R2 op with wel granted", {grant, reject}, 2'b10);
    chk("R2 wel cleared after request", wel, 0);
    step(1, 0, 0, 1, '0, 6'd5);
    chk("R2 simultaneous set and request", {grant, reject, wel}, 3'b010);
    step(0, 0, 0, 0, '0, '0);
    chk("R11 idle cycle quiet", {grant, reject}, 2'b00);

    foreach (VEC[i]) begin
      cfg(VEC[i][10], VEC[i][9:7], 1'b0);
      step(1, 0, 0, 0, '0, '0);
      step(0, 0, 0, 1, '0, VEC[i][6:1]);
      chk($sformatf("R6/R7/R8/R9 vector %0d", i), {grant, reject}, {VEC[i][0], ~VEC[i][0]});
    end

    cfg(1'b0, 3'd0, 1'b0); step(1, 0, 0, 0, '0, '0); step(0, 0, 1, 0, '0, '0);
    chk("R10 chip erase bp0 dir0", {grant, reject}, 2'b10);
    cfg(1'b1, 3'd0, 1'b0); step(1, 0, 0, 0, '0, '0); step(0, 0, 1, 0, '0, '0);
    chk("R10 chip erase bp0 dir1", {grant, reject}, 2'b10);
    cfg(1'b0, 3'd1, 1'b0); step(1, 0, 0, 0, '0, '0); step(0, 0, 1, 0, '0, '0);
    chk("R10 chip erase bp1 refused", {grant, reject}, 2'b01);
    cfg(1'b1, 3'd4, 1'b0); step(1, 0, 0, 0, '0, '0); step(0, 0, 1, 0, '0, '0);
    chk("R10 chip erase bp4 refused", {grant, reject}, 2'b01);

    cfg(1'b0, 3'd3, 1'b1);
    chk("R4 fields loaded", {grant, srwd, dir, bp}, {1'b1, 1'b1, 1'b0, 3'd3});
    @(negedge clk); wp_n = 0;
    step(1, 0, 0, 0, '0, '0);
    step(0, 1, 0, 0, 5'b01000, '0);
    chk("R5 frozen write granted", {grant, reject}, 2'b10);
    chk("R5 frozen bp/srwd held, dir loaded", {srwd, dir, bp}, {1'b1, 1'b1, 3'd3});
    @(negedge clk); wp_n = 1;
    cfg(1'b0, 3'd0, 1'b0);
    chk("R5 pin high releases freeze", {srwd, dir, bp}, 0);
    @(negedge clk); wp_n = 0;
    cfg(1'b1, 3'd5, 1'b0);
    chk("R5 srwd 0 ignores pin", {srwd, dir, bp}, {1'b0, 1'b1, 3'd5});
    @(negedge clk); wp_n = 1;

    cfg(1'b0, 3'd0, 1'b0);
    step(1, 0, 0, 0, '0, '0);
    step(0, 1, 1, 1, 5'b00111, 6'd0);
    chk("R12 status write wins", {grant, reject, bp}, {2'b10, 3'd7});
    step(1, 0, 0, 0, '0, '0); step(0, 0, 0, 1, '0, 6'd0);
    chk("R12 new code applied", {grant, reject}, 2'b01);
    cfg(1'b0, 3'd1, 1'b0);
    step(1, 0, 0, 0, '0, '0);
    step(0, 0, 1, 1, '0, 6'd0);
    chk("R12 chip erase wins over sector op", {grant, reject}, 2'b01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule